// File: doc/BRIEF.md
# Synchronous Burst-Read WAIT Generator

This block drives the WAIT pin of a memory that supports synchronous burst reads. After an address-latch cycle it counts the configured initial latency. It then walks the burst word address through a 16-word wordline, one word per clock. The first time the burst runs off the end of a wordline, it holds WAIT asserted for a number of extra cycles that depends on the latency count and on where the burst started. The asserted level of WAIT is set by a configuration bit. WAIT is put in high impedance, through a separate drive-enable output, whenever the bus is not in an active read cycle.

The access kind comes in on a 2-bit input: 0 is a synchronous array read, 1 is a synchronous nonarray read (status, identifier, query), 2 is an asynchronous read and 3 is a write. A read-mode bit chooses synchronous (0) or asynchronous (1) operation. A data-valid strobe marks every cycle in which WAIT shows valid data, so the data path can capture words without decoding WAIT itself.

Top module: `burst_wait_gen`

## Requirements
- R1: When `cfg_wait_hi` is 1, asserted WAIT is driven as 1 and deasserted WAIT as 0. When it is 0, both levels are inverted.
- R2: `wait_drive` is 1 only while `chip_sel_n` is 0, `out_en_n` is 0 and `srst` is 0. In every other case WAIT is in high impedance.
- R3: While `cfg_async` is 1, or `acc_mode` is 2 (asynchronous read) or 3 (write), driven WAIT stays at its deasserted level and `data_valid` stays 0.
- R4: Take a burst latched with a supported latency L at edge E0, where `addr_latch`=1 and `chip_sel_n`=0, with `out_en_n` held at 0. WAIT stays asserted in synchronous read modes (`acc_mode` 0 or 1, `cfg_async` 0) until edge E(L-1). From that edge on, it shows valid data.
- R5: After the first valid word, WAIT stays deasserted for one cycle per word, from start word S up to word 15 of the wordline.
- R6: On the first crossing from word 15 to word 0, WAIT is asserted for max(0, L-1-(16-S)) cycles. Valid data then continues with no further wait states, including at later crossings. In array mode this holds for every burst.
- R7: In nonarray mode (`acc_mode` 1), crossing wait states are inserted only for the first burst latched after `chip_sel_n` falls. Later bursts in the same chip-select period cross with no wait states.
- R8: A latency of 0 or 1 is unsupported. A burst latched with it never shows valid data, and WAIT stays asserted in synchronous read modes.
- R9: While `chip_sel_n` is 0 and `out_en_n` is 1, the latency, address and wait-state counters hold. When `out_en_n` falls again, progress resumes where it stopped.
- R10: `srst`=1 or `chip_sel_n`=1 at a clock edge abandons any burst. Until the next address latch, synchronous read modes show WAIT asserted.
- R11: `data_valid` is 1 exactly in the cycles where WAIT is driven deasserted in a synchronous read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr_latch | input | 1 | Address-latch strobe, starts a burst |
| start_word | input | 4 | Word offset of the burst start within its wordline |
| acc_mode | input | 2 | 0 sync array, 1 sync nonarray, 2 async read, 3 write |
| cfg_async | input | 1 | Read mode: 0 synchronous, 1 asynchronous |
| cfg_wait_hi | input | 1 | WAIT polarity: 1 asserted high |
| cfg_latency | input | 4 | Initial latency count in clocks |
| wait_pin | output | 1 | WAIT level |
| wait_drive | output | 1 | WAIT output enable (0 = high impedance) |
| data_valid | output | 1 | Valid data word on the bus this cycle |

## Verification
The hardest situation to reach is the one-time wordline-crossing gap. It shows up only after the initial latency has elapsed and the burst has consumed every word to the end of the wordline. Its length is a function of both L and S, and in nonarray mode it also depends on whether an earlier burst already ran in the same chip-select period. The bench sweeps every supported latency against every start offset. It compares each sampled cycle with a model of the full pattern, long enough to pass a second crossing. It then latches back-to-back nonarray bursts without releasing chip select, and afterwards releases it, to show the gap is lost and then regained.

// File: rtl/bwg_pkg.sv
`timescale 1ns/1ps
package bwg_pkg;
  typedef enum logic [1:0] {
    ACC_SYNC_ARRAY    = 2'd0,
    ACC_SYNC_NONARRAY = 2'd1,
    ACC_ASYNC_READ    = 2'd2,
    ACC_WRITE         = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/bwg_lat_ctr.sv
`timescale 1ns/1ps
module bwg_lat_ctr #(
  parameter int LAT_W   = 4,
  parameter int LAT_MIN = 2,
  parameter int LAT_MAX = 15
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             clr,
  input  logic             start,
  input  logic             adv_en,
  input  logic [LAT_W-1:0] lat_cfg,
  output logic             busy,
  output logic             lat_done
);
  logic [LAT_W-1:0] cnt;
  logic             lat_ok;

  assign lat_ok = (lat_cfg >= LAT_W'(LAT_MIN)) && (lat_cfg <= LAT_W'(LAT_MAX));

  always_ff @(posedge clk) begin
    if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= lat_ok;
      cnt  <= lat_cfg - 1'b1;
    end else if (adv_en && busy && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign lat_done = busy && (cnt == '0);

  // R8
  unsup_idle_chk: assert property (@(posedge clk) disable iff (srst)
    (start && !clr && !lat_ok) |=> !busy);
  // R9
  lat_freeze_chk: assert property (@(posedge clk) disable iff (srst)
    (busy && !adv_en && !start && !clr) |=> $stable(cnt));
endmodule

// File: rtl/bwg_wl_walker.sv
`timescale 1ns/1ps
module bwg_wl_walker #(
  parameter int LAT_W    = 4,
  parameter int WL_WORDS = 16,
  localparam int ADDR_W  = $clog2(WL_WORDS)
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              clr,
  input  logic              start,
  input  logic              adv_en,
  input  logic              allow_gap,
  input  logic              lat_done,
  input  logic [LAT_W-1:0]  lat_cfg,
  input  logic [ADDR_W-1:0] start_word,
  output logic              word_valid
);
  logic [ADDR_W-1:0] word;
  logic [LAT_W-1:0]  gap_cnt, gap_len, gap_next;
  logic              crossed, gap_en;
  int                tail_i, gap_i;

  always_comb begin
    tail_i   = WL_WORDS - int'(start_word);
    gap_i    = int'(lat_cfg) - 1 - tail_i;
    gap_next = (gap_i > 0) ? LAT_W'(gap_i) : '0;
  end

  assign word_valid = lat_done && (gap_cnt == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      word    <= '0;
      gap_cnt <= '0;
      gap_len <= '0;
      crossed <= 1'b0;
      gap_en  <= 1'b0;
    end else if (start) begin
      word    <= start_word;
      gap_cnt <= '0;
      gap_len <= gap_next;
      crossed <= 1'b0;
      gap_en  <= allow_gap;
    end else if (adv_en) begin
      if (word_valid) begin
        word <= word + 1'b1;
        if (word == ADDR_W'(WL_WORDS - 1) && !crossed) begin
          crossed <= 1'b1;
          if (gap_en) gap_cnt <= gap_len;
        end
      end else if (lat_done && gap_cnt != '0) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end

  // R6
  gap_at_wrap_chk: assert property (@(posedge clk) disable iff (srst)
    $rose(gap_cnt != '0) |-> (word == '0));
  // R5
  word_step_chk: assert property (@(posedge clk) disable iff (srst)
    (word_valid && adv_en && !start && !clr) |=> (word == ADDR_W'($past(word) + 1'b1)));
endmodule

// File: rtl/bwg_pin_drv.sv
`timescale 1ns/1ps
module bwg_pin_drv (
  input  logic srst,
  input  logic chip_sel_n,
  input  logic out_en_n,
  input  logic sync_rd,
  input  logic word_valid,
  input  logic cfg_wait_hi,
  output logic wait_pin,
  output logic wait_drive,
  output logic data_valid
);
  logic asserted;

  assign asserted   = sync_rd && !word_valid;
  assign wait_drive = !srst && !chip_sel_n && !out_en_n;
  assign wait_pin   = asserted ? cfg_wait_hi : !cfg_wait_hi;
  assign data_valid = wait_drive && sync_rd && word_valid;
endmodule

// File: rtl/burst_wait_gen.sv
`timescale 1ns/1ps
module burst_wait_gen
  import bwg_pkg::*;
#(
  parameter int LAT_W    = 4,
  parameter int LAT_MIN  = 2,
  parameter int LAT_MAX  = 15,
  parameter int WL_WORDS = 16,
  localparam int ADDR_W  = $clog2(WL_WORDS)
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              addr_latch,
  input  logic [ADDR_W-1:0] start_word,
  input  logic [1:0]        acc_mode,
  input  logic              cfg_async,
  input  logic              cfg_wait_hi,
  input  logic [LAT_W-1:0]  cfg_latency,
  output logic              wait_pin,
  output logic              wait_drive,
  output logic              data_valid
);
  logic clr, start, adv_en, busy, lat_done, word_valid;
  logic na_used, allow_gap, sync_rd;
  acc_mode_e mode;

  assign mode      = acc_mode_e'(acc_mode);
  assign clr       = srst || chip_sel_n;
  assign start     = !chip_sel_n && addr_latch;
  assign adv_en    = !chip_sel_n && !out_en_n;
  assign sync_rd   = !cfg_async && (mode == ACC_SYNC_ARRAY || mode == ACC_SYNC_NONARRAY);
  assign allow_gap = (mode == ACC_SYNC_ARRAY) || (mode == ACC_SYNC_NONARRAY && !na_used);

  always_ff @(posedge clk) begin
    if (clr)                                  na_used <= 1'b0;
    else if (start && mode == ACC_SYNC_NONARRAY) na_used <= 1'b1;
  end

  bwg_lat_ctr #(.LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)) u_lat (
    .clk(clk), .srst(srst), .clr(clr), .start(start), .adv_en(adv_en),
    .lat_cfg(cfg_latency), .busy(busy), .lat_done(lat_done)
  );

  bwg_wl_walker #(.LAT_W(LAT_W), .WL_WORDS(WL_WORDS)) u_walk (
    .clk(clk), .srst(srst), .clr(clr), .start(start), .adv_en(adv_en),
    .allow_gap(allow_gap), .lat_done(lat_done), .lat_cfg(cfg_latency),
    .start_word(start_word), .word_valid(word_valid)
  );

  bwg_pin_drv u_pin (
    .srst(srst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .sync_rd(sync_rd),
    .word_valid(word_valid), .cfg_wait_hi(cfg_wait_hi),
    .wait_pin(wait_pin), .wait_drive(wait_drive), .data_valid(data_valid)
  );

  // R11
  dv_level_chk: assert property (@(posedge clk) disable iff (srst)
    data_valid |-> (wait_drive && wait_pin == !cfg_wait_hi));
  // R3
  async_level_chk: assert property (@(posedge clk) disable iff (srst)
    (wait_drive && (cfg_async || acc_mode[1])) |-> (wait_pin == !cfg_wait_hi && !data_valid));
  // R10
  idle_after_clr_chk: assert property (@(posedge clk) disable iff (srst)
    (chip_sel_n && !addr_latch) |=> !data_valid);
endmodule

// File: tb/burst_wait_gen_bench.sv
`timescale 1ns/1ps
module burst_wait_gen_bench;
  logic       clk = 1'b0;
  logic       srst, chip_sel_n, out_en_n, addr_latch, cfg_async, cfg_wait_hi;
  logic [3:0] start_word, cfg_latency;
  logic [1:0] acc_mode;
  logic       wait_pin, wait_drive, data_valid;
  int nvec = 0, nfail = 0;
  bit done = 0;
  localparam int NS = 60;

  always #2.5 clk = ~clk;

  burst_wait_gen u_burst_wait_gen (
    .clk(clk), .srst(srst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .addr_latch(addr_latch), .start_word(start_word), .acc_mode(acc_mode),
    .cfg_async(cfg_async), .cfg_wait_hi(cfg_wait_hi), .cfg_latency(cfg_latency),
    .wait_pin(wait_pin), .wait_drive(wait_drive), .data_valid(data_valid)
  );

  // {polarity, async, mode[1:0], latency[3:0], start[3:0]}
  localparam logic [11:0] VEC [12] = '{
    {1'b1, 1'b0, 2'd0, 4'd4,  4'd0},   // R4 R5
    {1'b0, 1'b0, 2'd0, 4'd4,  4'd14},  // R1 R6
    {1'b0, 1'b0, 2'd1, 4'd9,  4'd10},  // R1 R6
    {1'b1, 1'b0, 2'd0, 4'd15, 4'd15},  // R6 max gap
    {1'b1, 1'b0, 2'd0, 4'd2,  4'd15},  // R6 zero gap
    {1'b1, 1'b0, 2'd0, 4'd0,  4'd3},   // R8
    {1'b0, 1'b0, 2'd1, 4'd1,  4'd3},   // R8
    {1'b1, 1'b0, 2'd2, 4'd5,  4'd7},   // R3
    {1'b0, 1'b0, 2'd3, 4'd5,  4'd7},   // R3
    {1'b1, 1'b1, 2'd0, 4'd6,  4'd1},   // R3
    {1'b0, 1'b1, 2'd1, 4'd6,  4'd1},   // R3
    {1'b0, 1'b0, 2'd0, 4'd7,  4'd12}   // R11
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic bit exp_valid(int k, int lat, int s, bit gap_on);
    int p, n1, ws;
    if (lat < 2 || lat > 15) return 0;
    if (k < lat - 1) return 0;
    p  = k - (lat - 1);
    n1 = 16 - s;
    ws = (gap_on && (lat - 1 - n1) > 0) ? lat - 1 - n1 : 0;
    if (p < n1) return 1;
    if (p < n1 + ws) return 0;
    return 1;
  endfunction

  task automatic fail(string req, string what, int act, int exp);
    nfail++;
    $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic check_bit(string req, string what, logic act, logic exp);
    nvec++;
    if (act !== exp) fail(req, what, int'(act), int'(exp));
  endtask

  // Runs one burst and compares every sampled cycle; counts as one vector.
  task automatic run_burst(string req, bit pol, bit asy, int mode, int lat, int s,
                           bit gap_on, bit fresh);
    bit sync, ev, bad;
    bad = 0;
    cfg_wait_hi = pol; cfg_async = asy; acc_mode = 2'(mode);
    cfg_latency = 4'(lat); start_word = 4'(s); out_en_n = 1'b0;
    if (fresh) begin chip_sel_n = 1'b1; tick(); chip_sel_n = 1'b0; end
    addr_latch = 1'b1; tick(); addr_latch = 1'b0;
    sync = !asy && mode < 2;
    for (int k = 0; k < NS; k++) begin
      ev = sync && exp_valid(k, lat, s, gap_on);
      if (!bad && (wait_drive !== 1'b1 || data_valid !== ev ||
                   wait_pin !== ((sync && !ev) ? pol : !pol))) begin
        bad = 1;
        nfail++;
        $display("FAIL %s: L=%0d S=%0d mode=%0d k=%0d actual pin/dv=%0d/%0d expected=%0d/%0d",
                 req, lat, s, mode, k, wait_pin, data_valid,
                 (sync && !ev) ? pol : !pol, ev);
      end
      tick();
    end
    nvec++;
  endtask

  initial begin
    srst = 1'b1; chip_sel_n = 1'b1; out_en_n = 1'b0; addr_latch = 1'b0;
    cfg_async = 1'b0; cfg_wait_hi = 1'b1; cfg_latency = 4'd4; start_word = '0;
    acc_mode = 2'd0;
    tick(); tick();
    chip_sel_n = 1'b0; #1;
    check_bit("R2", "drive during reset", wait_drive, 1'b0);
    srst = 1'b0; chip_sel_n = 1'b1; tick();
    check_bit("R2", "drive with chip select high", wait_drive, 1'b0);
    chip_sel_n = 1'b0; out_en_n = 1'b1; #1;
    check_bit("R2", "drive with output enable high", wait_drive, 1'b0);
    out_en_n = 1'b0; tick();
    check_bit("R10", "idle wait asserted", wait_pin, 1'b1);

    for (int i = 0; i < 12; i++) begin
      logic [11:0] v;
      v = VEC[i];
      run_burst("R1 R3 R4 R5 R8 R11", v[11], v[10], int'(v[9:8]), int'(v[7:4]),
                int'(v[3:0]), 1'b1, 1'b1);
    end

    // R6: every supported latency against every start offset
    for (int l = 2; l <= 15; l++)
      for (int s = 0; s < 16; s++)
        run_burst("R6", 1'b1, 1'b0, 0, l, s, 1'b1, 1'b1);

    // R6: array mode keeps the gap on a second burst in the same select period
    run_burst("R6", 1'b1, 1'b0, 0, 10, 13, 1'b1, 1'b1);
    run_burst("R6", 1'b1, 1'b0, 0, 10, 13, 1'b1, 1'b0);
    // R7: nonarray gap only on the first burst after select falls
    run_burst("R7", 1'b1, 1'b0, 1, 8, 12, 1'b1, 1'b1);
    run_burst("R7", 1'b1, 1'b0, 1, 8, 12, 1'b0, 1'b0);
    run_burst("R7", 1'b1, 1'b0, 1, 8, 12, 1'b1, 1'b1);

    // R9: output enable high freezes the latency count
    cfg_wait_hi = 1'b1; cfg_async = 1'b0; acc_mode = 2'd0; cfg_latency = 4'd4; start_word = 4'd0;
    chip_sel_n = 1'b1; tick(); chip_sel_n = 1'b0; out_en_n = 1'b1;
    addr_latch = 1'b1; tick(); addr_latch = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    check_bit("R9", "drive while output enable high", wait_drive, 1'b0);
    out_en_n = 1'b0; #1;
    check_bit("R9", "still waiting after freeze", wait_pin, 1'b1);
    tick(); tick();
    check_bit("R9", "no data two edges after resume", data_valid, 1'b0);
    tick();
    check_bit("R9", "data third edge after resume", data_valid, 1'b1);

    // R10: chip select pulse abandons the burst
    tick();
    chip_sel_n = 1'b1; tick(); chip_sel_n = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    check_bit("R10", "wait asserted after select release", wait_pin, 1'b1);
    check_bit("R10", "no data after select release", data_valid, 1'b0);
    // R10: reset abandons the burst
    cfg_latency = 4'd2; addr_latch = 1'b1; tick(); addr_latch = 1'b0; tick(); tick();
    check_bit("R5", "streaming before reset", data_valid, 1'b1);
    srst = 1'b1; tick(); srst = 1'b0; tick(); tick();
    check_bit("R10", "no data after reset", data_valid, 1'b0);
    check_bit("R10", "wait asserted after reset", wait_pin, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule